// File: doc/BRIEF.md
# Byte-Acknowledged Serial Bus Slave Receiver

This block is the receive side of a two-wire serial bus slave (SMBus/I2C electrical and framing rules). It samples the clock and data wires with the system clock, finds START and STOP conditions, and shifts in the address byte with its direction bit and then any data bytes. The block does not match addresses itself. After the eighth bit of every byte it raises an interrupt and an acknowledge-request flag. It holds the bus clock low until the host has answered.

The host reads the byte from the data output and writes an acknowledge decision. It then clears the interrupt. Only then does the block release the clock and drive the ninth bit with the host's answer. The data wire is pulled low for ACK and left released for NACK. If the host refuses the address, the block stays silent until the next START. If the host writes the data register during an accepted transfer, the block stops receiving, lets go of both wires and reports a change to transmit mode. Write transfers are the only kind received. Reads, arbitration, timeouts and master operation are not handled.

Top module: `smbs_slave_rx`

## Requirements
- R1: After reset, irq, ackrq, scl_drive_low, sda_drive_low, rx_active and tx_mode are all 0.
- R2: With inhibit at 0, a START followed by an address byte whose bit 0 (the direction bit, the last bit on the wire) is 0 (write) sets irq and ackrq after the eighth SCL rising edge. rx_data then holds the whole byte, MSB first on the wire, and rx_is_addr is 1.
- R3: If inhibit is 1, or the address direction bit is 1 (read), no interrupt is raised. SCL is not held and SDA is not driven, so the address reads as NACK on the bus.
- R4: Once SCL is low after the eighth bit of an interrupting byte, scl_drive_low holds SCL low. It releases SCL only when the host has pulsed host_ack_wr and irq has been cleared with host_irq_clr. Either one alone does not release it.
- R5: During the ninth clock, sda_drive_low equals the host's decision: host_ack_val 1 means ACK and pulls SDA low, 0 means NACK and leaves SDA released. SDA is released after the ninth SCL falling edge, and it is never driven outside a byte's acknowledge window.
- R6: After an accepted address, each data byte sets irq and ackrq before its acknowledge clock. rx_data holds the byte and rx_is_addr is 0. rx_active is 1 while a transfer is accepted.
- R7: After a NACKed address, later bytes raise no interrupt, hold no clock and drive no SDA until a START is seen.
- R8: A STOP ends the transfer: rx_active and tx_mode go to 0.
- R9: A repeated START restarts address reception and brings back interrupts that an earlier NACK had suppressed.
- R10: A host_dat_wr pulse while rx_active is 1 sets tx_mode, clears rx_active and releases SCL and SDA. tx_mode stays 1 until the next START or STOP.
- R11: ackrq falls when the acknowledge bit starts to be driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock wire level |
| sda_in | input | 1 | Bus data wire level |
| scl_drive_low | output | 1 | 1 pulls the clock wire low (stretch) |
| sda_drive_low | output | 1 | 1 pulls the data wire low (acknowledge) |
| inhibit | input | 1 | 1 suppresses slave events |
| host_ack_wr | input | 1 | One-cycle strobe writing the acknowledge decision |
| host_ack_val | input | 1 | Decision written by host_ack_wr: 1 ACK, 0 NACK |
| host_irq_clr | input | 1 | One-cycle strobe clearing irq |
| host_dat_wr | input | 1 | One-cycle strobe of a host data register write |
| irq | output | 1 | Interrupt flag |
| ackrq | output | 1 | Acknowledge decision pending |
| rx_data | output | DATA_W | Last received byte |
| rx_is_addr | output | 1 | rx_data is an address byte |
| rx_active | output | 1 | An accepted write transfer is in progress |
| tx_mode | output | 1 | Block has switched to slave transmit |

## Verification
The bench drives the bus through wired-AND lines, so a stretch the design forgets to hold shows up as an early rising edge. It releases its own clock before the host answers and checks that the line stays low. It does this with the decision written but the interrupt still set. A design that released on the ACK write alone, or on the interrupt clear alone, fails that check. Every clock it checks that SDA and SCL are pulled only inside the acknowledge window and that no interrupt appears after a NACKed address or an inhibited or read address. Leaking SDA, or a NACK that did not stick until the next START, would be caught there. It also checks that a repeated START brings interrupts back, and that a data-register write mid-transfer drops the stretch and moves to transmit mode until STOP.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AWAIT,
        ST_AACK,
        ST_DATA,
        ST_DWAIT,
        ST_DACK,
        ST_IGNORE,
        ST_TX
    } rx_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic st_shifting(rx_state_t s);
        return (s == ST_ADDR) || (s == ST_DATA);
    endfunction

    function automatic logic st_waiting(rx_state_t s);
        return (s == ST_AWAIT) || (s == ST_DWAIT);
    endfunction

    function automatic logic st_acking(rx_state_t s);
        return (s == ST_AACK) || (s == ST_DACK);
    endfunction

    function automatic logic st_accepted(rx_state_t s);
        return (s == ST_DATA) || (s == ST_DWAIT) || (s == ST_DACK);
    endfunction

endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], d_in[gi]};
                end
            end
            assign d_out[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/smbs_busmon.sv
module smbs_busmon
    import smbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smbs_shifter.sv
module smbs_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_next,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= word_next;
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    assign word_next = {sh_q[W-2:0], bit_in};
    assign last      = (cnt_q == LAST_IDX);
endmodule

// File: rtl/smbs_slave_rx.sv
module smbs_slave_rx
    import smbs_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              inhibit,
    input  logic              host_ack_wr,
    input  logic              host_ack_val,
    input  logic              host_irq_clr,
    input  logic              host_dat_wr,
    output logic              irq,
    output logic              ackrq,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_is_addr,
    output logic              rx_active,
    output logic              tx_mode
);
    logic        scl_s, sda_s;
    bus_evt_t    evt;
    logic        start_det, stop_det;
    rx_state_t   state_q;
    logic        hold_q, sda_low_q, ack_done_q, ack_val_q, seen_rise_q;
    logic        irq_q, irq_set;
    logic        shift_en, shift_clr, shift_last;
    logic [DATA_W-1:0] word_next;

    smbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({scl_in, sda_in}),
        .d_out ({scl_s, sda_s})
    );

    smbs_busmon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    assign start_det = evt.start;
    assign stop_det  = evt.stop;
    assign shift_en  = evt.scl_rise & st_shifting(state_q) & ~start_det & ~stop_det;
    assign shift_clr = start_det | ~st_shifting(state_q);

    smbs_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (shift_clr),
        .shift_en  (shift_en),
        .bit_in    (sda_s),
        .word_next (word_next),
        .last      (shift_last)
    );

    // Interrupt is raised when a byte that needs a host decision completes.
    always_comb begin
        irq_set = 1'b0;
        if (!start_det && !stop_det && shift_en && shift_last) begin
            if (state_q == ST_DATA) begin
                irq_set = 1'b1;
            end else if (!inhibit && !word_next[0]) begin
                irq_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (irq_set) begin
            irq_q <= 1'b1;
        end else if (host_irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            hold_q      <= 1'b0;
            sda_low_q   <= 1'b0;
            ack_done_q  <= 1'b0;
            ack_val_q   <= 1'b0;
            seen_rise_q <= 1'b0;
            ackrq       <= 1'b0;
            rx_data     <= '0;
            rx_is_addr  <= 1'b0;
        end else if (start_det || stop_det) begin
            state_q     <= start_det ? ST_ADDR : ST_IDLE;
            hold_q      <= 1'b0;
            sda_low_q   <= 1'b0;
            ack_done_q  <= 1'b0;
            seen_rise_q <= 1'b0;
            ackrq       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (shift_en && shift_last) begin
                        if (irq_set) begin
                            state_q    <= ST_AWAIT;
                            ackrq      <= 1'b1;
                            ack_done_q <= 1'b0;
                            rx_data    <= word_next;
                            rx_is_addr <= 1'b1;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                ST_DATA: begin
                    if (host_dat_wr) begin
                        state_q <= ST_TX;
                    end else if (shift_en && shift_last) begin
                        state_q    <= ST_DWAIT;
                        ackrq      <= 1'b1;
                        ack_done_q <= 1'b0;
                        rx_data    <= word_next;
                        rx_is_addr <= 1'b0;
                    end
                end
                ST_AWAIT, ST_DWAIT: begin
                    if (host_ack_wr) begin
                        ack_done_q <= 1'b1;
                        ack_val_q  <= host_ack_val;
                    end
                    if (state_q == ST_DWAIT && host_dat_wr) begin
                        state_q <= ST_TX;
                        hold_q  <= 1'b0;
                        ackrq   <= 1'b0;
                    end else if (hold_q && ack_done_q && !irq_q) begin
                        state_q     <= (state_q == ST_AWAIT) ? ST_AACK : ST_DACK;
                        hold_q      <= 1'b0;
                        ackrq       <= 1'b0;
                        sda_low_q   <= ack_val_q;
                        seen_rise_q <= 1'b0;
                    end else begin
                        hold_q <= hold_q | ~scl_s;
                    end
                end
                ST_AACK, ST_DACK: begin
                    if (state_q == ST_DACK && host_dat_wr) begin
                        state_q   <= ST_TX;
                        sda_low_q <= 1'b0;
                    end else begin
                        if (evt.scl_rise) begin
                            seen_rise_q <= 1'b1;
                        end
                        if (evt.scl_fall && seen_rise_q) begin
                            sda_low_q <= 1'b0;
                            if (state_q == ST_AACK && !ack_val_q) begin
                                state_q <= ST_IGNORE;
                            end else begin
                                state_q <= ST_DATA;
                            end
                        end
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    assign scl_drive_low = hold_q;
    assign sda_drive_low = sda_low_q;
    assign irq           = irq_q;
    assign rx_active     = st_accepted(state_q);
    assign tx_mode       = (state_q == ST_TX);
endmodule

module smbs_slave_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_drive_low,
    input logic              sda_drive_low,
    input logic              irq,
    input logic              ackrq,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_is_addr,
    input logic              rx_active,
    input logic              tx_mode,
    input logic              start_det,
    input logic              stop_det
);
    assert_irq_has_ackrq_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ackrq);

    assert_addr_is_write_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && rx_is_addr) |-> !rx_data[0]);

    assert_stretch_pending_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> ackrq);

    assert_release_needs_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_drive_low) |-> (!irq || tx_mode));

    assert_sda_after_stretch_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> $past(scl_drive_low));

    assert_ackrq_drops_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !ackrq);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!rx_active && !tx_mode));

    assert_restart_addr_R9: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!rx_active && !tx_mode && !scl_drive_low));

    assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        tx_mode |-> (!scl_drive_low && !sda_drive_low && !rx_active));
endmodule

bind smbs_slave_rx smbs_slave_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .irq           (irq),
    .ackrq         (ackrq),
    .rx_data       (rx_data),
    .rx_is_addr    (rx_is_addr),
    .rx_active     (rx_active),
    .tx_mode       (tx_mode),
    .start_det     (start_det),
    .stop_det      (stop_det)
);

// File: tb/sim_smbs_slave_rx.sv
`timescale 1ns/1ps
module sim_smbs_slave_rx;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_in, sda_in;
    logic scl_drive_low, sda_drive_low;
    logic inhibit = 1'b0;
    logic host_ack_wr = 1'b0, host_ack_val = 1'b0, host_irq_clr = 1'b0, host_dat_wr = 1'b0;
    logic irq, ackrq, rx_is_addr, rx_active, tx_mode;
    logic [7:0] rx_data;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;
    bit drv_ok = 0;
    bit quiet = 0;
    bit run = 0;

    always #5 clk = ~clk;

    assign scl_in = scl_m & ~scl_drive_low;
    assign sda_in = sda_m & ~sda_drive_low;

    smbs_slave_rx u0 (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .inhibit(inhibit), .host_ack_wr(host_ack_wr), .host_ack_val(host_ack_val),
        .host_irq_clr(host_irq_clr), .host_dat_wr(host_dat_wr),
        .irq(irq), .ackrq(ackrq), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
        .rx_active(rx_active), .tx_mode(tx_mode)
    );

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Per-clock reference: drives only inside the acknowledge window, no irq when quiet.
    always @(negedge clk) begin
        cyc++;
        if (run) begin
            if (!drv_ok) begin
                chk("R5", "sda driven outside ack window", int'(sda_drive_low), 0);
                chk("R4", "scl held outside ack window", int'(scl_drive_low), 0);
            end
            if (quiet) begin
                chk("R7", "irq while suppressed", int'(irq), 0);
            end
        end
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wclk(T);
        scl_m = 1'b1; wclk(T);
        sda_m = 1'b0; wclk(T);
        scl_m = 1'b0; wclk(T);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wclk(T);
        scl_m = 1'b1; wclk(T);
        sda_m = 1'b1; wclk(T);
    endtask

    // Eight bits MSB first; ends with SCL low one half period after the last fall.
    task automatic m_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(T);
            scl_m = 1'b1; wclk(T);
            if (i == 0) drv_ok = 1;
            scl_m = 1'b0; wclk(T);
        end
    endtask

    // Ninth clock; returns 1 when the line was pulled low (ACK).
    task automatic m_ack_clock(output bit acked);
        int guard;
        sda_m = 1'b1;
        scl_m = 1'b1;
        guard = 0;
        while (scl_in == 1'b0 && guard < 2000) begin
            wclk(1);
            guard++;
        end
        wclk(T);
        acked = ~sda_in;
        scl_m = 1'b0;
        wclk(T);
        drv_ok = 0;
    endtask

    task automatic h_ack(bit v);
        host_ack_val = v; host_ack_wr = 1'b1; wclk(1);
        host_ack_wr = 1'b0; wclk(1);
    endtask

    task automatic h_clr();
        host_irq_clr = 1'b1; wclk(1);
        host_irq_clr = 1'b0; wclk(1);
    endtask

    task automatic h_dat();
        host_dat_wr = 1'b1; wclk(1);
        host_dat_wr = 1'b0; wclk(1);
    endtask

    // Accepted byte: check flags, answer, run the ack clock and check the bus result.
    task automatic byte_answer(string req, logic [7:0] b, bit is_addr, bit ackv);
        bit acked;
        m_byte(b);
        chk(req, "irq after byte", int'(irq), 1);
        chk(req, "ackrq after byte", int'(ackrq), 1);
        chk(req, "rx_data", int'(rx_data), int'(b));
        chk(req, "rx_is_addr", int'(rx_is_addr), int'(is_addr));
        chk("R4", "scl held", int'(scl_drive_low), 1);
        h_ack(ackv);
        h_clr();
        m_ack_clock(acked);
        chk("R5", "ack on bus", int'(acked), int'(ackv));
        chk("R11", "ackrq cleared", int'(ackrq), 0);
        chk("R5", "sda released after ninth clock", int'(sda_drive_low), 0);
    endtask

    initial begin
        bit acked;
        wclk(4);
        rst = 1'b0;
        wclk(2);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "ackrq", int'(ackrq), 0);
        chk("R1", "scl_drive_low", int'(scl_drive_low), 0);
        chk("R1", "sda_drive_low", int'(sda_drive_low), 0);
        chk("R1", "rx_active", int'(rx_active), 0);
        chk("R1", "tx_mode", int'(tx_mode), 0);
        run = 1;

        // Accepted write address with the stretch probed step by step.
        m_start();
        m_byte(8'hA4);
        chk("R2", "irq on write address", int'(irq), 1);
        chk("R2", "ackrq on write address", int'(ackrq), 1);
        chk("R2", "address byte", int'(rx_data), 8'hA4);
        chk("R2", "rx_is_addr", int'(rx_is_addr), 1);
        chk("R4", "scl held after eighth bit", int'(scl_drive_low), 1);
        sda_m = 1'b1;
        scl_m = 1'b1;
        wclk(30);
        chk("R4", "line low before host answer", int'(scl_in), 0);
        h_ack(1'b1);
        wclk(10);
        chk("R4", "line low with irq still set", int'(scl_in), 0);
        h_clr();
        m_ack_clock(acked);
        chk("R5", "address ACK on bus", int'(acked), 1);
        chk("R11", "ackrq after address ack", int'(ackrq), 0);
        chk("R5", "sda released", int'(sda_drive_low), 0);
        chk("R6", "rx_active after accept", int'(rx_active), 1);

        byte_answer("R6", 8'h3C, 1'b0, 1'b0);
        byte_answer("R6", 8'hC5, 1'b0, 1'b1);
        chk("R6", "still active", int'(rx_active), 1);
        m_stop();
        wclk(5);
        chk("R8", "rx_active after stop", int'(rx_active), 0);
        chk("R8", "tx_mode after stop", int'(tx_mode), 0);

        // NACKed address, ignored byte, then repeated START.
        m_start();
        byte_answer("R2", 8'h52, 1'b1, 1'b0);
        quiet = 1;
        m_byte(8'hFF);
        chk("R7", "no irq after nacked address", int'(irq), 0);
        chk("R7", "no stretch after nacked address", int'(scl_drive_low), 0);
        m_ack_clock(acked);
        chk("R7", "no ack after nacked address", int'(acked), 0);
        quiet = 0;
        m_start();
        byte_answer("R9", 8'h52, 1'b1, 1'b1);
        m_byte(8'h81);
        chk("R9", "data irq after restart", int'(irq), 1);
        chk("R6", "data byte 81", int'(rx_data), 8'h81);
        h_dat();
        wclk(2);
        chk("R10", "tx_mode after data write", int'(tx_mode), 1);
        chk("R10", "rx_active after data write", int'(rx_active), 0);
        chk("R10", "scl released", int'(scl_drive_low), 0);
        h_clr();
        m_ack_clock(acked);
        chk("R10", "no ack in tx mode", int'(acked), 0);
        chk("R10", "tx_mode held", int'(tx_mode), 1);
        m_stop();
        wclk(5);
        chk("R10", "tx_mode cleared by stop", int'(tx_mode), 0);

        // Inhibited, then read-direction address.
        inhibit = 1'b1;
        quiet = 1;
        m_start();
        m_byte(8'hA4);
        chk("R3", "no irq when inhibited", int'(irq), 0);
        chk("R3", "no stretch when inhibited", int'(scl_drive_low), 0);
        m_ack_clock(acked);
        chk("R3", "nack when inhibited", int'(acked), 0);
        m_stop();
        inhibit = 1'b0;
        m_start();
        m_byte(8'hA5);
        chk("R3", "no irq on read address", int'(irq), 0);
        m_ack_clock(acked);
        chk("R3", "nack on read address", int'(acked), 0);
        m_stop();
        quiet = 0;
        wclk(10);
        summary();
    end
endmodule